// File: doc/BRIEF.md
# Backlight Fade Sequencer

This block owns the 5-bit code that sets the backlight sink current. When software writes a new code with fading switched on, the block does not jump to it. It walks the live code one count at a time toward the new value and takes one count per step interval. A 2-bit rate selector sets the interval as a number of millisecond ticks. Software may change the rate during a walk, and it may cancel a walk by switching fading off. Cancelling snaps the code straight to the destination. With fading off, a written code takes effect on the next clock.

The controller has two named states. `ST_IDLE` accepts writes. `ST_RAMP` walks the code and ignores writes. Four transitions connect them:
- `ST_IDLE -> ST_RAMP` (start): a write arrives with fading on and a code that differs from the live one.
- `ST_RAMP -> ST_RAMP` (step): the step timer expires before the walk is done.
- `ST_RAMP -> ST_IDLE` (arrive): a step lands on the destination.
- `ST_RAMP -> ST_IDLE` (cancel): fading is switched off.

The `busy` output reports `ST_RAMP` to the register interface. The block also drives a lookup output. It gives the sink current that the live code stands for, in units of 0.5 mA. The current table is nonlinear, and this output lets the table be checked.

Top module: `bl_fade_seq`

## Requirements
- R1: With fading on, an accepted write whose code differs from the live code moves `level_code` by exactly one count toward it at each step, until the two are equal.
- R2: The step interval is 8·(4 − rate_sel) ticks of `ms_tick`: 00 gives 32, 01 gives 24, 10 gives 16 and 11 gives 8. With a tick on every clock, each step lands on the interval-th tick counted from the start of that step.
- R3: A whole walk takes |new − old| × interval ticks. A walk from 0 to 31 at rate 00 takes 992 ticks.
- R4: A change to `rate_sel` during a walk applies from then on. The step in progress completes on the first tick at which the ticks counted since that step began reach the new interval.
- R5: Driving `fade_en` low during a walk sets `level_code` to the destination on the next clock and clears `busy`. `fading` equals `busy` AND `fade_en`.
- R6: While `busy` is high, `wr_en` has no effect. The walk keeps its original destination and stops there.
- R7: With `fade_en` low, a write sets `level_code` to `wr_code` on the next clock and leaves `busy` low.
- R8: `level_half_ma` gives the current for code c in 0.5 mA units. For c ≤ 23 it is c+1 (0.5 to 12 mA). Codes 24, 25 and 26 give 26, 28 and 30 (13, 14 and 15 mA). Codes 27 to 31 give 34, 38, 42, 46 and 50 (17 to 25 mA in 2 mA steps).
- R9: `busy` rises on the clock after a differing write is accepted with fading on. It falls on the same clock on which `level_code` reaches the destination. A write equal to the live code with fading on leaves `busy` low.
- R10: After reset, `level_code` is 0, `busy` and `fading` are low, and `level_half_ma` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe that writes `wr_code` |
| wr_code | input | 5 | New current code |
| fade_en | input | 1 | Turns fading on |
| rate_sel | input | 2 | Selects the step interval |
| ms_tick | input | 1 | Millisecond time base, one cycle per tick |
| level_code | output | 5 | Live current code |
| busy | output | 1 | A walk is under way and writes are refused |
| fading | output | 1 | A walk is under way and fading is still on |
| level_half_ma | output | 6 | Current for `level_code`, in 0.5 mA units |

## Verification
Four properties are checked on every clock:
- while walking with fading on, the code never moves by more than one count per clock;
- a refused write never disturbs the latched destination;
- cancelling always lands the code on the destination;
- `busy` only falls when the code equals the destination.

The lookup output is checked on every evaluation to stay in range and to rise strictly with the code.

Some behaviour can only be shown by the bench's scenarios:
- the exact tick on which each step lands, for every rate;
- the effect of a rate change in the middle of a step;
- the total walk length for a full-scale fade;
- the table values themselves.

// File: rtl/fade_pkg.sv
package fade_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RAMP = 1'b1
    } fade_state_e;

    // current in half-milliamp units for a code
    function automatic logic [5:0] code_half_ma(input logic [4:0] c);
        logic [5:0] cw;
        cw = {1'b0, c};
        if (cw < 6'd24)
            return cw + 6'd1;
        else if (cw < 6'd27)
            return 6'd26 + ((cw - 6'd24) << 1);
        else
            return 6'd34 + ((cw - 6'd27) << 2);
    endfunction

endpackage

// File: rtl/fade_step_timer.sv
module fade_step_timer #(
    parameter int BASE_TICKS = 8,
    parameter int RATE_W     = 2,
    parameter int CNT_W      = $clog2(BASE_TICKS * (1 << RATE_W) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              step_due
);
    localparam int NRATES = 1 << RATE_W;

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] interval;

    // interval shrinks by one base unit per rate code
    always_comb begin
        interval = CNT_W'(BASE_TICKS * (NRATES - int'(rate)));
    end

    // compare against the live interval so a rate change applies mid-step
    always_comb begin
        step_due = run && tick && ((elapsed + CNT_W'(1)) >= interval);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed <= '0;
        else if (!run || step_due)
            elapsed <= '0;
        else if (tick)
            elapsed <= elapsed + CNT_W'(1);
    end

    assert_restart_after_step_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        step_due |=> (elapsed == '0)
    );

    assert_hold_without_tick_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (run && !tick && $past(run)) |=> (elapsed == $past(elapsed))
    );

endmodule

// File: rtl/fade_level_lut.sv
module fade_level_lut
    import fade_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int OUT_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  half_ma
);
    always_comb begin
        half_ma = OUT_W'(code_half_ma(5'(code)));
    end

    always_comb begin
        assert_lut_range_R8: assert (half_ma >= OUT_W'(1) && half_ma <= OUT_W'(50));
        if (code != '0) begin
            assert_lut_rising_R8: assert (half_ma > OUT_W'(code_half_ma(5'(code - CODE_W'(1)))));
        end
    end

endmodule

// File: rtl/fade_ctrl_fsm.sv
module fade_ctrl_fsm
    import fade_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              fade_en,
    input  logic              step_due,
    output logic [CODE_W-1:0] level_code,
    output logic              busy,
    output logic              timer_run
);
    fade_state_e      state, state_nx;
    logic [CODE_W-1:0] dest_q, dest_nx;
    logic [CODE_W-1:0] level_q, level_nx;
    logic [CODE_W-1:0] stepped;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            dest_q  <= '0;
            level_q <= '0;
        end else begin
            state   <= state_nx;
            dest_q  <= dest_nx;
            level_q <= level_nx;
        end
    end

    always_comb begin
        stepped = (dest_q > level_q) ? level_q + CODE_W'(1) : level_q - CODE_W'(1);
    end

    // next state and datapath
    always_comb begin
        state_nx = state;
        dest_nx  = dest_q;
        level_nx = level_q;
        unique case (state)
            ST_IDLE: begin
                if (wr_en) begin
                    dest_nx = wr_code;
                    if (fade_en && (wr_code != level_q))
                        state_nx = ST_RAMP;          // start
                    else
                        level_nx = wr_code;          // immediate
                end
            end
            ST_RAMP: begin
                if (!fade_en) begin
                    level_nx = dest_q;               // cancel
                    state_nx = ST_IDLE;
                end else if (step_due) begin
                    level_nx = stepped;              // step
                    if (stepped == dest_q)
                        state_nx = ST_IDLE;          // arrive
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        level_code = level_q;
        busy       = (state == ST_RAMP);
        timer_run  = (state == ST_RAMP);
    end

    assert_one_count_per_clock_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && fade_en) |=> ((level_q == $past(level_q)) ||
                               (level_q == $past(level_q) + CODE_W'(1)) ||
                               (level_q == $past(level_q) - CODE_W'(1)))
    );

    assert_refused_write_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> (dest_q == $past(dest_q))
    );

    assert_cancel_jump_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (busy && !fade_en) |=> ((level_q == $past(dest_q)) && !busy)
    );

    assert_release_at_dest_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (level_q == dest_q)
    );

endmodule

// File: rtl/bl_fade_seq.sv
module bl_fade_seq
    import fade_pkg::*;
#(
    parameter int CODE_W     = 5,
    parameter int RATE_W     = 2,
    parameter int BASE_TICKS = 8,
    parameter int OUT_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              fade_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              ms_tick,
    output logic [CODE_W-1:0] level_code,
    output logic              busy,
    output logic              fading,
    output logic [OUT_W-1:0]  level_half_ma
);
    localparam int CNT_W = $clog2(BASE_TICKS * (1 << RATE_W) + 1);

    logic step_due;
    logic timer_run;

    fade_step_timer #(
        .BASE_TICKS(BASE_TICKS),
        .RATE_W    (RATE_W),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .tick    (ms_tick),
        .rate    (rate_sel),
        .step_due(step_due)
    );

    fade_ctrl_fsm #(
        .CODE_W(CODE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_code   (wr_code),
        .fade_en   (fade_en),
        .step_due  (step_due),
        .level_code(level_code),
        .busy      (busy),
        .timer_run (timer_run)
    );

    fade_level_lut #(
        .CODE_W(CODE_W),
        .OUT_W (OUT_W)
    ) u_lut (
        .code   (level_code),
        .half_ma(level_half_ma)
    );

    always_comb begin
        fading = busy && fade_en;
    end

endmodule

// File: tb/test_bl_fade_seq.sv
module test_bl_fade_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_code = '0;
    logic       fade_en = 1'b0;
    logic [1:0] rate_sel = '0;
    logic       ms_tick = 1'b1;
    logic [4:0] level_code;
    logic       busy;
    logic       fading;
    logic [5:0] level_half_ma;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bl_fade_seq i_bl_fade_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_code      (wr_code),
        .fade_en      (fade_en),
        .rate_sel     (rate_sel),
        .ms_tick      (ms_tick),
        .level_code   (level_code),
        .busy         (busy),
        .fading       (fading),
        .level_half_ma(level_half_ma)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // returns at the first negedge after the write edge
    task automatic write_code(input logic [4:0] c);
        @(negedge clk);
        wr_code = c;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int interval_of(input int r);
        return 8 * (4 - r);
    endfunction

    task automatic do_fade(input int from, input int to, input int r);
        int n;
        int lvl;
        n = interval_of(r);
        fade_en = 1'b0;
        rate_sel = 2'(r);
        write_code(5'(from));
        check(level_code == 5'(from), "R7", level_code, from);
        fade_en = 1'b1;
        write_code(5'(to));
        check(busy == 1'b1, "R9", busy, 1);
        lvl = from;
        while (lvl != to) begin
            repeat (n - 1) @(negedge clk);
            check(level_code == 5'(lvl), "R2", level_code, lvl);
            @(negedge clk);
            lvl = (to > lvl) ? lvl + 1 : lvl - 1;
            check(level_code == 5'(lvl), "R1", level_code, lvl);
        end
        check(busy == 1'b0 && fading == 1'b0, "R9", busy, 0);
    endtask

    initial begin
        int exp;
        int cnt;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(level_code == 5'd0, "R10", level_code, 0);
        check(busy == 1'b0 && fading == 1'b0, "R10", busy, 0);
        check(level_half_ma == 6'd1, "R10", level_half_ma, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 and R7: exhaustive table sweep with fading off
        exp = 1;
        for (int c = 0; c < 32; c++) begin
            if (c > 0) exp += (c <= 23) ? 1 : ((c <= 26) ? 2 : 4);
            write_code(5'(c));
            check(level_code == 5'(c) && !busy, "R7", level_code, c);
            check(level_half_ma == 6'(exp), "R8", level_half_ma, exp);
        end

        // R1/R2: fades up and down at every rate
        for (int r = 0; r < 4; r++) begin
            do_fade(r * 7, r * 7 + 4, r);
            do_fade(r * 7 + 4, r * 7 + 1, r);
        end

        // R9: equal code with fading on does not start a walk
        fade_en = 1'b1;
        write_code(level_code);
        check(busy == 1'b0, "R9", busy, 0);

        // R3: full-scale walk at the slowest rate
        fade_en = 1'b0;
        rate_sel = 2'd0;
        write_code(5'd0);
        fade_en = 1'b1;
        write_code(5'd31);
        cnt = 0;
        while (busy && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 31 * 32, "R3", cnt, 992);
        check(level_code == 5'd31, "R3", level_code, 31);

        // R4: rate change mid-step, 10 ticks already counted
        fade_en = 1'b0;
        write_code(5'd10);
        fade_en = 1'b1;
        rate_sel = 2'd0;
        write_code(5'd13);
        repeat (10) @(negedge clk);
        rate_sel = 2'd3;
        @(negedge clk);
        check(level_code == 5'd11, "R4", level_code, 11);
        repeat (7) @(negedge clk);
        check(level_code == 5'd11, "R4", level_code, 11);
        @(negedge clk);
        check(level_code == 5'd12, "R4", level_code, 12);

        // R5: cancel mid-walk jumps to destination
        check(fading == 1'b1, "R5", fading, 1);
        fade_en = 1'b0;
        #1;
        check(fading == 1'b0 && busy == 1'b1, "R5", fading, 0);
        @(negedge clk);
        check(level_code == 5'd13 && !busy, "R5", level_code, 13);

        // R6: write during walk is ignored
        fade_en = 1'b1;
        rate_sel = 2'd3;
        write_code(5'd16);
        @(negedge clk);
        wr_code = 5'd2;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cnt = 0;
        while (busy && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        check(level_code == 5'd16, "R6", level_code, 16);
        repeat (40) @(negedge clk);
        check(level_code == 5'd16 && !busy, "R6", level_code, 16);

        done = 1'b1;
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule